// File: doc/BRIEF.md
# Paged Data Memory Address Unit

This unit serves the load and store path of a small 8-bit load-store processor. It builds a 16-bit data address from three 8-bit values. A dedicated page register supplies the high byte unchanged. The low byte is the base register plus the instruction's 8-bit offset, and this sum wraps inside the current page. The unit decodes the address into one of three regions and returns the read byte from the selected region. The regions are a fixed read-only table, a writable scratch memory and a small bank of I/O registers.

The map is as follows:
- The table occupies 0x0000–0x0FFF (4 KiB).
- The scratch memory occupies 0x1000–0x1FFF (4 KiB).
- The I/O bank occupies 0x2000–0x2003 (4 bytes).
- Every other address is unmapped. It returns zero and discards writes.

An access lasts one cycle while `acc_en` is high. A read is combinational from the current operands. A write takes effect on the next rising clock edge. The processor pipeline holds one access per cycle and never stalls, so the edge of this unit has no valid/ready pair: `acc_en` is a plain qualifier.

Top module: `dmem_paged_unit`

## Requirements
- R1: `addr_o[15:8]` always equals `page_i`.
- R2: `addr_o[7:0]` equals `(base_i + imm_i) mod 256`. The carry out of the sum is dropped and never changes the page (for example, page 0x1F, base 0xFF, offset 0x01 gives 0x1F00).
- R3: While `acc_en` is high, exactly one select is asserted for a mapped address, and none for an unmapped one. The selects are `cs_rom_o` for 0x0000–0x0FFF, `cs_ram_o` for 0x1000–0x1FFF and `cs_io_o` for 0x2000–0x2003.
- R4: A table read at offset `o` (12 bits) returns `o[7:0] XOR {o[11:8], o[11:8]}`. Writes to the table region leave its contents unchanged.
- R5: A write to the scratch region with `acc_en` and `acc_we` high stores `wdata_i` on the rising edge. A later read of the same address returns that byte. A write with `acc_en` low stores nothing.
- R6: The four I/O registers are cleared by reset and can each be written and read back independently.
- R7: Reads from unmapped addresses return 0x00. Writes to them alter no mapped location, including the I/O register that would alias at 0x2004.
- R8: `err_o` is high during the cycle after an accepted unmapped access and low after any other cycle.
- R9: While `acc_en` is low, all selects are low and `rdata_o` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_en | input | 1 | An access is presented this cycle |
| acc_we | input | 1 | The access is a write (1) or a read (0) |
| page_i | input | 8 | Page register value, the high address byte |
| base_i | input | 8 | Base register value |
| imm_i | input | 8 | Instruction offset |
| wdata_i | input | 8 | Store data |
| addr_o | output | 16 | Effective address |
| cs_rom_o | output | 1 | Table region selected |
| cs_ram_o | output | 1 | Scratch region selected |
| cs_io_o | output | 1 | I/O region selected |
| rdata_o | output | 8 | Read data from the selected region |
| err_o | output | 1 | Previous access was unmapped |

## Verification
The assertions assume that `acc_en`, `acc_we` and the operands are settled before each rising edge and held over it. They also assume that scratch bytes are read only after they have been written, because the scratch memory has no reset. The bench drives every operand at the falling edge and writes each scratch address before reading it. The carry-wrap and alias cases use the same timing as the rest of the table.

// File: rtl/dmem_pkg.sv
package dmem_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 2 * BYTE_W;
  localparam int N_REGION = 3;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [ADDR_W-1:0] addr_t;

  typedef enum logic [1:0] {
    RGN_NONE = 2'd0,
    RGN_ROM  = 2'd1,
    RGN_RAM  = 2'd2,
    RGN_IO   = 2'd3
  } region_e;
endpackage

// File: rtl/dmem_agen.sv
module dmem_agen
  import dmem_pkg::*;
(
  input  byte_t page_i,
  input  byte_t base_i,
  input  byte_t imm_i,
  output addr_t addr_o
);
  byte_t lo_sum;

  always_comb begin
    lo_sum = base_i + imm_i;
    addr_o = {page_i, lo_sum};
  end
endmodule

// File: rtl/dmem_decode.sv
module dmem_decode
  import dmem_pkg::*;
#(
  parameter int ROM_BASE  = 0,
  parameter int ROM_BYTES = 4096,
  parameter int RAM_BASE  = 4096,
  parameter int RAM_BYTES = 4096,
  parameter int IO_BASE   = 8192,
  parameter int IO_BYTES  = 4,
  localparam int ROM_AW = $clog2(ROM_BYTES),
  localparam int RAM_AW = $clog2(RAM_BYTES),
  localparam int IO_AW  = (IO_BYTES > 1) ? $clog2(IO_BYTES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  addr_t             addr_i,
  output region_e           region_o,
  output logic [ROM_AW-1:0] rom_off_o,
  output logic [RAM_AW-1:0] ram_off_o,
  output logic [IO_AW-1:0]  io_off_o
);
  int a;
  logic in_rom, in_ram, in_io;

  always_comb begin
    a = int'(addr_i);
    in_rom = (a >= ROM_BASE) && (a < ROM_BASE + ROM_BYTES);
    in_ram = (a >= RAM_BASE) && (a < RAM_BASE + RAM_BYTES);
    in_io  = (a >= IO_BASE)  && (a < IO_BASE + IO_BYTES);
    region_o = RGN_NONE;
    if (en_i) begin
      if (in_rom)      region_o = RGN_ROM;
      else if (in_ram) region_o = RGN_RAM;
      else if (in_io)  region_o = RGN_IO;
    end
    rom_off_o = ROM_AW'(a - ROM_BASE);
    ram_off_o = RAM_AW'(a - RAM_BASE);
    io_off_o  = IO_AW'(a - IO_BASE);
  end

  // R3: the address ranges must not overlap
  p_one_region_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({in_rom, in_ram, in_io}));
endmodule

// File: rtl/dmem_rom.sv
module dmem_rom
  import dmem_pkg::*;
#(
  parameter int ROM_BYTES = 4096,
  localparam int ROM_AW = $clog2(ROM_BYTES)
) (
  input  logic [ROM_AW-1:0] off_i,
  output byte_t             data_o
);
  // Read-only contents, generated from the offset by a fixed rule
  function automatic byte_t table_byte(input logic [ROM_AW-1:0] off);
    byte_t hi_nib;
    hi_nib = BYTE_W'(off >> BYTE_W);
    return BYTE_W'(off) ^ BYTE_W'(hi_nib * 8'h11);
  endfunction

  always_comb data_o = table_byte(off_i);
endmodule

// File: rtl/dmem_ram.sv
module dmem_ram
  import dmem_pkg::*;
#(
  parameter int RAM_BYTES = 4096,
  localparam int RAM_AW = $clog2(RAM_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [RAM_AW-1:0] off_i,
  input  byte_t             wdata_i,
  output byte_t             rdata_o
);
  byte_t mem [RAM_BYTES];

  always_ff @(posedge clk) begin
    if (we_i) mem[off_i] <= wdata_i;
  end

  always_comb rdata_o = mem[off_i];

  // R5: a qualified write lands at its address
  p_store_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> (mem[$past(off_i)] == $past(wdata_i)));
endmodule

// File: rtl/dmem_io.sv
module dmem_io
  import dmem_pkg::*;
#(
  parameter int IO_BYTES = 4,
  localparam int IO_AW = (IO_BYTES > 1) ? $clog2(IO_BYTES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [IO_AW-1:0] off_i,
  input  byte_t            wdata_i,
  output byte_t            rdata_o
);
  byte_t regs [IO_BYTES];

  for (genvar g = 0; g < IO_BYTES; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               regs[g] <= '0;
      else if (we_i && (int'(off_i) == g))      regs[g] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < IO_BYTES; i++)
      if (int'(off_i) == i) rdata_o = regs[i];
  end

  // R6: register 0 keeps its value unless it is written
  p_io_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(we_i && (int'(off_i) == 0)) |=> $stable(regs[0]));
endmodule

// File: rtl/dmem_paged_unit.sv
module dmem_paged_unit
  import dmem_pkg::*;
#(
  parameter int ROM_BASE  = 0,
  parameter int ROM_BYTES = 4096,
  parameter int RAM_BASE  = 4096,
  parameter int RAM_BYTES = 4096,
  parameter int IO_BASE   = 8192,
  parameter int IO_BYTES  = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acc_en,
  input  logic        acc_we,
  input  logic [7:0]  page_i,
  input  logic [7:0]  base_i,
  input  logic [7:0]  imm_i,
  input  logic [7:0]  wdata_i,
  output logic [15:0] addr_o,
  output logic        cs_rom_o,
  output logic        cs_ram_o,
  output logic        cs_io_o,
  output logic [7:0]  rdata_o,
  output logic        err_o
);
  localparam int ROM_AW = $clog2(ROM_BYTES);
  localparam int RAM_AW = $clog2(RAM_BYTES);
  localparam int IO_AW  = (IO_BYTES > 1) ? $clog2(IO_BYTES) : 1;

  addr_t             addr;
  region_e           region;
  logic [ROM_AW-1:0] rom_off;
  logic [RAM_AW-1:0] ram_off;
  logic [IO_AW-1:0]  io_off;
  byte_t             rom_q, ram_q, io_q;
  logic              miss;
  logic              err_q;

  dmem_agen u_agen (
    .page_i (page_i),
    .base_i (base_i),
    .imm_i  (imm_i),
    .addr_o (addr)
  );

  dmem_decode #(
    .ROM_BASE (ROM_BASE), .ROM_BYTES (ROM_BYTES),
    .RAM_BASE (RAM_BASE), .RAM_BYTES (RAM_BYTES),
    .IO_BASE  (IO_BASE),  .IO_BYTES  (IO_BYTES)
  ) u_decode (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (acc_en),
    .addr_i    (addr),
    .region_o  (region),
    .rom_off_o (rom_off),
    .ram_off_o (ram_off),
    .io_off_o  (io_off)
  );

  dmem_rom #(.ROM_BYTES (ROM_BYTES)) u_rom (
    .off_i  (rom_off),
    .data_o (rom_q)
  );

  dmem_ram #(.RAM_BYTES (RAM_BYTES)) u_ram (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (acc_we && (region == RGN_RAM)),
    .off_i   (ram_off),
    .wdata_i (wdata_i),
    .rdata_o (ram_q)
  );

  dmem_io #(.IO_BYTES (IO_BYTES)) u_io (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (acc_we && (region == RGN_IO)),
    .off_i   (io_off),
    .wdata_i (wdata_i),
    .rdata_o (io_q)
  );

  always_comb begin
    addr_o   = addr;
    cs_rom_o = (region == RGN_ROM);
    cs_ram_o = (region == RGN_RAM);
    cs_io_o  = (region == RGN_IO);
    miss     = acc_en && (region == RGN_NONE);
    unique case (region)
      RGN_ROM: rdata_o = rom_q;
      RGN_RAM: rdata_o = ram_q;
      RGN_IO:  rdata_o = io_q;
      default: rdata_o = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= miss;
  end
  assign err_o = err_q;

  // R8: an unmapped access flags an error in the following cycle
  p_err_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !(cs_rom_o || cs_ram_o || cs_io_o)) |=> err_o);
  // R8: no access means no error in the next cycle
  p_err_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_en |=> !err_o);
  // R9: an idle port drives nothing
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_en |-> (rdata_o == 8'h00 && !cs_rom_o && !cs_ram_o && !cs_io_o));
  // R7: unmapped reads return zero
  p_oob_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !(cs_rom_o || cs_ram_o || cs_io_o)) |-> (rdata_o == 8'h00));
  // R1: the page byte passes through to the address
  p_page_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
    addr_o[15:8] == page_i);
endmodule

// File: tb/dmem_paged_unit_bench.sv
module dmem_paged_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_en = 1'b0, acc_we = 1'b0;
  logic [7:0]  page_i = '0, base_i = '0, imm_i = '0, wdata_i = '0;
  logic [15:0] addr_o;
  logic        cs_rom_o, cs_ram_o, cs_io_o, err_o;
  logic [7:0]  rdata_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dmem_paged_unit u_dmem_paged_unit (
    .clk (clk), .rst_n (rst_n), .acc_en (acc_en), .acc_we (acc_we),
    .page_i (page_i), .base_i (base_i), .imm_i (imm_i), .wdata_i (wdata_i),
    .addr_o (addr_o), .cs_rom_o (cs_rom_o), .cs_ram_o (cs_ram_o),
    .cs_io_o (cs_io_o), .rdata_o (rdata_o), .err_o (err_o)
  );

  typedef struct packed {
    logic        we;
    logic [7:0]  page;
    logic [7:0]  base;
    logic [7:0]  imm;
    logic [7:0]  wd;
    logic [15:0] ea;
    logic [2:0]  cs;   // {io, ram, rom}
    logic [7:0]  rd;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 8'h00, 8'h10, 8'h05, 8'h00, 16'h0015, 3'b001, 8'h15}, // R4 table
    '{1'b0, 8'h0A, 8'hF0, 8'h20, 8'h00, 16'h0A10, 3'b001, 8'hBA}, // R2 wrap, R4
    '{1'b1, 8'h00, 8'h00, 8'h15, 8'hFF, 16'h0015, 3'b001, 8'h00}, // R4 write try
    '{1'b0, 8'h00, 8'h15, 8'h00, 8'h00, 16'h0015, 3'b001, 8'h15}, // R4 unchanged
    '{1'b1, 8'h10, 8'h20, 8'h03, 8'h5A, 16'h1023, 3'b010, 8'h00}, // R5 store
    '{1'b1, 8'h1F, 8'hFF, 8'h01, 8'hC3, 16'h1F00, 3'b010, 8'h00}, // R2 carry drop
    '{1'b0, 8'h10, 8'h00, 8'h23, 8'h00, 16'h1023, 3'b010, 8'h5A}, // R5 readback
    '{1'b0, 8'h1F, 8'h80, 8'h80, 8'h00, 16'h1F00, 3'b010, 8'hC3}, // R2, R5
    '{1'b1, 8'h20, 8'h00, 8'h00, 8'h11, 16'h2000, 3'b100, 8'h00}, // R6 write
    '{1'b1, 8'h20, 8'h01, 8'h02, 8'h44, 16'h2003, 3'b100, 8'h00}, // R6 write
    '{1'b0, 8'h20, 8'h00, 8'h00, 8'h00, 16'h2000, 3'b100, 8'h11}, // R6 read
    '{1'b0, 8'h20, 8'h03, 8'h00, 8'h00, 16'h2003, 3'b100, 8'h44}, // R6 read
    '{1'b0, 8'h20, 8'h00, 8'h01, 8'h00, 16'h2001, 3'b100, 8'h00}, // R6 untouched
    '{1'b1, 8'h20, 8'h02, 8'h02, 8'h99, 16'h2004, 3'b000, 8'h00}, // R7 write
    '{1'b0, 8'h20, 8'h04, 8'h00, 8'h00, 16'h2004, 3'b000, 8'h00}, // R7 read
    '{1'b0, 8'h20, 8'h00, 8'h00, 8'h00, 16'h2000, 3'b100, 8'h11}, // R7 no alias
    '{1'b1, 8'h30, 8'h00, 8'h00, 8'h77, 16'h3000, 3'b000, 8'h00}, // R7
    '{1'b0, 8'hFF, 8'hF0, 8'h0F, 8'h00, 16'hFFFF, 3'b000, 8'h00}  // R7, R1
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rom_exp(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[11:8]};
  endfunction

  task automatic drive(input logic en, input logic we, input logic [7:0] pg,
                       input logic [7:0] bs, input logic [7:0] im, input logic [7:0] wd);
    @(negedge clk);
    acc_en = en; acc_we = we; page_i = pg; base_i = bs; imm_i = im; wdata_i = wd;
    #1;
  endtask

  initial begin
    #150000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R9 reset cs", {cs_io_o, cs_ram_o, cs_rom_o}, 3'b000);
    check("R9 reset rdata", rdata_o, 8'h00);
    check("R8 reset err", err_o, 1'b0);
    rst_n = 1'b1;

    // R6: reset value of every I/O register
    for (int i = 0; i < 4; i++) begin
      drive(1'b1, 1'b0, 8'h20, 8'(i), 8'h00, 8'h00);
      check("R6 reset value", rdata_o, 8'h00);
    end

    for (int v = 0; v < NV; v++) begin
      drive(1'b1, TBL[v].we, TBL[v].page, TBL[v].base, TBL[v].imm, TBL[v].wd);
      check("R1 R2 address", addr_o, TBL[v].ea);
      check("R3 selects", {cs_io_o, cs_ram_o, cs_rom_o}, TBL[v].cs);
      if (!TBL[v].we) begin
        if (TBL[v].cs == 3'b001)
          check("R4 table byte", rdata_o, rom_exp(TBL[v].ea));
        check("R4 R5 R6 R7 read data", rdata_o, TBL[v].rd);
      end
      @(posedge clk); #1;
      check("R8 error flag", err_o, (TBL[v].cs == 3'b000));
    end

    // R8: flag lasts one cycle after an unmapped access
    drive(1'b1, 1'b0, 8'h40, 8'h00, 8'h00, 8'h00);
    drive(1'b0, 1'b0, 8'h40, 8'h00, 8'h00, 8'h00);
    check("R8 pulse high", err_o, 1'b1);
    @(posedge clk); #1;
    check("R8 pulse low", err_o, 1'b0);

    // R9: idle port on a mapped address
    drive(1'b0, 1'b1, 8'h10, 8'h23, 8'h00, 8'h00);
    check("R9 idle cs", {cs_io_o, cs_ram_o, cs_rom_o}, 3'b000);
    check("R9 idle rdata", rdata_o, 8'h00);
    // R5: that unqualified write must not have landed
    drive(1'b1, 1'b0, 8'h10, 8'h23, 8'h00, 8'h00);
    check("R5 no store when idle", rdata_o, 8'h5A);

    // R4: far corner of the table
    drive(1'b1, 1'b0, 8'h0F, 8'hF0, 8'h0F, 8'h00);
    check("R4 last table byte", rdata_o, rom_exp(16'h0FFF));

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule